// File: doc/BRIEF.md
# Interrupt Flag Aggregation Controller

This block collects event lines from pins and from on-chip sources and turns each edge into a latched flag bit. It then presents seven main interrupt request lines to the processor core. Four pins drive main lines 0, 1, 3 and 5 directly. Lines 2, 4 and 6 are each fed by the OR of a group of sub-source flags, gated by an enable: two flash-collision events go to line 2, the rising and falling edges of a PLL-lock signal go to line 4, and a transfer-busy event and a one-second clock tick go to line 6. An auto-wake status flag sits beside the sub-source flags but raises no interrupt.

The block clears main-line flags in hardware when the core acknowledges the matching vector. Software clears sub-source flags by writing a byte with a zero at each bit to be cleared; a written one leaves its flag untouched, so one flag can be cleared without a read-modify-write race. Each merged line detects the edge of its OR, not its level. A sub-flag left set therefore masks later events on the same line, and firmware has to clear every sub-flag of a line before it leaves the service routine.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, all main and sub-source flags, the main enables (addr 0), the sub enables (addr 2) and the polarity bits (addr 4) read 0, and `irq_o` is 0.
- R2: Register map for the combinational read port. Addr 0 holds the read/write main enables in bits [6:0], one per line. Addr 1 reads the main flags in bits [6:0], and writes to it are ignored. Addr 2 holds the sub enables in bits [3:0]: bit0 transfer, bit1 clock tick, bit2 flash group, bit3 PLL group. Addr 4 holds the polarity bits [1:0]: bit0 for line 2 and bit1 for line 3, where 1 selects falling. Bits not listed read 0, and addr 3 holds the sub-source flags.
- R3: A rising edge on `ext_pin_i[0]` sets main flag 0, on `ext_pin_i[1]` sets flag 1, and a falling edge on the active-low `ext_pin_i[3]` sets flag 5. The flag is visible after the third rising clock edge that follows the pin change. A steady level never sets a flag again.
- R4: Line 3 sets on the edge of `ext_pin_i[2]` that polarity bit1 selects. Line 2 sets on the edge of its merged flash signal that polarity bit0 selects.
- R5: `ack_i[n]` clears main flag n on the next clock edge, and `irq_o[n]` is main flag n AND main enable n.
- R6: Sub-source flags at addr 3 are laid out as follows: bit0 is set by a falling `xfer_busy_ni`, bit1 by a falling `rtc_tick_ni`, bit2 and bit3 by a rising `flash_col_i[0]` and `flash_col_i[1]`, bit4 by a rising `pll_lock_i`, bit5 by a falling `pll_lock_i`, and bit6 (auto-wake) by a rising `wake_tmo_i`.
- R7: A write to addr 3 clears exactly the sub-source flags whose data bit is 0. Data bits that are 1, and writes to any other address, leave the flags unchanged.
- R8: A hardware set of a flag in the same cycle as its clear, whether by write or by acknowledge, leaves the flag set.
- R9: Line 6 sets on a rising edge of (bit0 AND sub-enable bit0) OR (bit1 AND sub-enable bit1). Line 4 sets on a rising edge of sub-enable bit3 AND (bit4 OR bit5). Line 2 sets on an edge of sub-enable bit2 AND (bit2 OR bit3). Setting an enable while its flag is set counts as such an edge.
- R10: While the merged signal of a line stays high, no further sub-source event sets its main flag again. A new request needs all of that line's sub-flags to be cleared first.
- R11: The auto-wake flag sets no main flag and no `irq_o` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | 4 | Pins for lines 0, 1, 3 and 5; bit3 is active low |
| flash_col_i | input | 2 | Flash-collision events 0 and 1 |
| pll_lock_i | input | 1 | PLL-lock status |
| xfer_busy_ni | input | 1 | Transfer-busy event, active low |
| rtc_tick_ni | input | 1 | One-second tick, active low |
| wake_tmo_i | input | 1 | Wake-timer timeout |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` |
| ack_i | input | 7 | Per-line vector acknowledge |
| irq_o | output | 7 | Enabled main-line requests |

## Verification
All 256 data bytes are written to each configuration register, which separates implemented bits from tied-zero bits. For write-zero-to-clear, all 128 clear masks are swept over a full set of sub-flags, which tells a clear-on-zero flag apart from a plain register or a write-one-to-clear one. Single events on each source confirm the bit position and the edge direction. Paired events on line 6, with clears in between, show the difference between a level-sensitive merge and the edge behaviour that produces the lock-up. A clear timed to land in the same cycle as a set shows which of the two wins.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int NUM_LINES = 7;
  localparam int SUB_W     = 7;
  localparam int SUB_EN_W  = 4;
  localparam int POL_W     = 2;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 8;

  localparam logic [ADDR_W-1:0] A_MAIN_EN   = 3'd0;
  localparam logic [ADDR_W-1:0] A_MAIN_FLAG = 3'd1;
  localparam logic [ADDR_W-1:0] A_SUB_EN    = 3'd2;
  localparam logic [ADDR_W-1:0] A_SUB_FLAG  = 3'd3;
  localparam logic [ADDR_W-1:0] A_POL       = 3'd4;

  // sub-source flag bits
  localparam int S_XFER = 0;
  localparam int S_RTC  = 1;
  localparam int S_FC0  = 2;
  localparam int S_FC1  = 3;
  localparam int S_PLLR = 4;
  localparam int S_PLLF = 5;
  localparam int S_WAKE = 6;

  // sub enable bits
  localparam int N_XFER = 0;
  localparam int N_RTC  = 1;
  localparam int N_FC   = 2;
  localparam int N_PLL  = 3;

  // synchronized event detectors
  localparam int E_PIN0  = 0;
  localparam int E_PIN1  = 1;
  localparam int E_PIN3  = 2;
  localparam int E_PIN5  = 3;
  localparam int E_FC0   = 4;
  localparam int E_FC1   = 5;
  localparam int E_PLLR  = 6;
  localparam int E_PLLF  = 7;
  localparam int E_XFER  = 8;
  localparam int E_RTC   = 9;
  localparam int E_WAKE  = 10;
  localparam int NUM_EVT = 11;

  // merged lines
  localparam int M_L2    = 0;
  localparam int M_L4    = 1;
  localparam int M_L6    = 2;
  localparam int NUM_MRG = 3;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic fall_i,
  output logic pulse_o
);
  logic s_q;
  logic prev_q;

  generate
    if (STAGES > 0) begin : g_sync
      logic [STAGES-1:0] sr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sr_q <= '0;
        end else begin
          sr_q[0] <= sig_i;
          for (int k = 1; k < STAGES; k++) sr_q[k] <= sr_q[k-1];
        end
      end
      assign s_q = sr_q[STAGES-1];
    end else begin : g_direct
      assign s_q = sig_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= s_q;
  end

  assign pulse_o = fall_i ? (prev_q & ~s_q) : (s_q & ~prev_q);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= set_i | (q_o & ~clr_i);
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_flag_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [NUM_LINES-1:0] main_flag_i,
  input  logic [SUB_W-1:0]     sub_flag_i,
  output logic [NUM_LINES-1:0] main_en_o,
  output logic [SUB_EN_W-1:0]  sub_en_o,
  output logic [POL_W-1:0]     pol_o,
  output logic [SUB_W-1:0]     sub_clr_o,
  output logic [DATA_W-1:0]    rdata_o
);
  logic unused_wdata;
  assign unused_wdata = wdata_i[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_en_o <= '0;
      sub_en_o  <= '0;
      pol_o     <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_MAIN_EN: main_en_o <= wdata_i[NUM_LINES-1:0];
        A_SUB_EN:  sub_en_o  <= wdata_i[SUB_EN_W-1:0];
        A_POL:     pol_o     <= wdata_i[POL_W-1:0];
        default: ;
      endcase
    end
  end

  // zero bits clear, one bits ignored
  assign sub_clr_o = (we_i && addr_i == A_SUB_FLAG) ? ~wdata_i[SUB_W-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_MAIN_EN:   rdata_o[NUM_LINES-1:0] = main_en_o;
      A_MAIN_FLAG: rdata_o[NUM_LINES-1:0] = main_flag_i;
      A_SUB_EN:    rdata_o[SUB_EN_W-1:0]  = sub_en_o;
      A_SUB_FLAG:  rdata_o[SUB_W-1:0]     = sub_flag_i;
      A_POL:       rdata_o[POL_W-1:0]     = pol_o;
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [3:0]           ext_pin_i,
  input  logic [1:0]           flash_col_i,
  input  logic                 pll_lock_i,
  input  logic                 xfer_busy_ni,
  input  logic                 rtc_tick_ni,
  input  logic                 wake_tmo_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  input  logic [NUM_LINES-1:0] ack_i,
  output logic [NUM_LINES-1:0] irq_o
);
  logic [NUM_LINES-1:0] main_en, main_flag, main_set;
  logic [SUB_EN_W-1:0]  sub_en;
  logic [POL_W-1:0]     pol;
  logic [SUB_W-1:0]     sub_flag, sub_set, sub_clr;
  logic [NUM_EVT-1:0]   evt_raw, evt_fall, evt_pulse;
  logic [NUM_MRG-1:0]   m_line, m_fall, m_pulse;

  // raw event lines; active-low sources inverted ahead of the synchronizer
  always_comb begin
    evt_raw          = '0;
    evt_fall         = '0;
    evt_raw[E_PIN0]  = ext_pin_i[0];
    evt_raw[E_PIN1]  = ext_pin_i[1];
    evt_raw[E_PIN3]  = ext_pin_i[2];
    evt_raw[E_PIN5]  = ~ext_pin_i[3];
    evt_raw[E_FC0]   = flash_col_i[0];
    evt_raw[E_FC1]   = flash_col_i[1];
    evt_raw[E_PLLR]  = pll_lock_i;
    evt_raw[E_PLLF]  = pll_lock_i;
    evt_raw[E_XFER]  = ~xfer_busy_ni;
    evt_raw[E_RTC]   = ~rtc_tick_ni;
    evt_raw[E_WAKE]  = wake_tmo_i;
    evt_fall[E_PIN3] = pol[1];
    evt_fall[E_PLLF] = 1'b1;
  end

  generate
    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
      irq_edge_det #(.STAGES(SYNC_STAGES)) u_det (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sig_i   (evt_raw[g]),
        .fall_i  (evt_fall[g]),
        .pulse_o (evt_pulse[g])
      );
    end
  endgenerate

  always_comb begin
    sub_set         = '0;
    sub_set[S_XFER] = evt_pulse[E_XFER];
    sub_set[S_RTC]  = evt_pulse[E_RTC];
    sub_set[S_FC0]  = evt_pulse[E_FC0];
    sub_set[S_FC1]  = evt_pulse[E_FC1];
    sub_set[S_PLLR] = evt_pulse[E_PLLR];
    sub_set[S_PLLF] = evt_pulse[E_PLLF];
    sub_set[S_WAKE] = evt_pulse[E_WAKE];
  end

  irq_flag_bank #(.W(SUB_W)) u_sub_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sub_set),
    .clr_i  (sub_clr),
    .q_o    (sub_flag)
  );

  // merged sub-source lines, edge detected on registered flags
  always_comb begin
    m_line       = '0;
    m_line[M_L2] = sub_en[N_FC] & (sub_flag[S_FC0] | sub_flag[S_FC1]);
    m_line[M_L4] = sub_en[N_PLL] & (sub_flag[S_PLLR] | sub_flag[S_PLLF]);
    m_line[M_L6] = (sub_en[N_XFER] & sub_flag[S_XFER]) |
                   (sub_en[N_RTC] & sub_flag[S_RTC]);
    m_fall       = '0;
    m_fall[M_L2] = pol[0];
  end

  generate
    for (genvar m = 0; m < NUM_MRG; m++) begin : g_mrg
      irq_edge_det #(.STAGES(0)) u_det (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sig_i   (m_line[m]),
        .fall_i  (m_fall[m]),
        .pulse_o (m_pulse[m])
      );
    end
  endgenerate

  always_comb begin
    main_set    = '0;
    main_set[0] = evt_pulse[E_PIN0];
    main_set[1] = evt_pulse[E_PIN1];
    main_set[2] = m_pulse[M_L2];
    main_set[3] = evt_pulse[E_PIN3];
    main_set[4] = m_pulse[M_L4];
    main_set[5] = evt_pulse[E_PIN5];
    main_set[6] = m_pulse[M_L6];
  end

  irq_flag_bank #(.W(NUM_LINES)) u_main_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (main_set),
    .clr_i  (ack_i),
    .q_o    (main_flag)
  );

  irq_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .main_flag_i (main_flag),
    .sub_flag_i  (sub_flag),
    .main_en_o   (main_en),
    .sub_en_o    (sub_en),
    .pol_o       (pol),
    .sub_clr_o   (sub_clr),
    .rdata_o     (reg_rdata_o)
  );

  assign irq_o = main_flag & main_en;
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk
  import irq_flag_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 reg_we_i,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic [DATA_W-1:0]    reg_wdata_i,
  input logic [NUM_LINES-1:0] ack_i,
  input logic [NUM_LINES-1:0] main_flag,
  input logic [NUM_LINES-1:0] main_set,
  input logic [SUB_W-1:0]     sub_flag,
  input logic [SUB_W-1:0]     sub_set,
  input logic [NUM_MRG-1:0]   m_line
);
  logic [SUB_W-1:0] wr_zero;
  assign wr_zero = (reg_we_i && reg_addr_i == A_SUB_FLAG) ? ~reg_wdata_i[SUB_W-1:0] : '0;

  assert_sub_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sub_flag & $past(sub_set)) == $past(sub_set)));

  assert_main_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((main_flag & $past(main_set)) == $past(main_set)));

  assert_no_set_by_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sub_flag & ~$past(sub_flag) & ~$past(sub_set)) == '0));

  assert_clear_only_by_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(sub_flag) & ~sub_flag & ~$past(wr_zero)) == '0));

  assert_ack_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((main_flag & $past(ack_i) & ~$past(main_set)) == '0));

  assert_no_retrigger_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_set[6] |-> !$past(m_line[M_L6]));

  assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_set[0] |=> !main_set[0]);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .ack_i       (ack_i),
  .main_flag   (main_flag),
  .main_set    (main_set),
  .sub_flag    (sub_flag),
  .sub_set     (sub_set),
  .m_line      (m_line)
);

// File: tb/test_irq_flag_ctrl.sv
`timescale 1ns/1ps
module test_irq_flag_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ext_pin = 4'b1000;
  logic [1:0] flash = 2'b00;
  logic       pll = 1'b0;
  logic       xfer_n = 1'b1;
  logic       rtc_n = 1'b1;
  logic       wake = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [6:0] ack = 7'h00;
  logic [6:0] irq;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  irq_flag_ctrl i_irq_flag_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ext_pin_i(ext_pin), .flash_col_i(flash),
    .pll_lock_i(pll), .xfer_busy_ni(xfer_n), .rtc_tick_ni(rtc_n), .wake_tmo_i(wake),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ack_i(ack), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rchk(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic ichk(input string req, input logic [6:0] exp);
    @(negedge clk); chk(req, irq, exp);
  endtask

  task automatic do_ack(input logic [6:0] m);
    @(negedge clk); ack = m;
    @(negedge clk); ack = 7'h00;
  endtask

  // 0 xfer,1 rtc,2 fc0,3 fc1,4 pll rise,5 pll fall,6 wake
  task automatic ev(input int s);
    case (s)
      0: begin xfer_n = 1'b0; tick(5); xfer_n = 1'b1; end
      1: begin rtc_n = 1'b0; tick(5); rtc_n = 1'b1; end
      2: begin flash[0] = 1'b1; tick(5); flash[0] = 1'b0; end
      3: begin flash[1] = 1'b1; tick(5); flash[1] = 1'b0; end
      4: pll = 1'b1;
      5: pll = 1'b0;
      default: begin wake = 1'b1; tick(5); wake = 1'b0; end
    endcase
    tick(6);
  endtask

  task automatic all_subs();
    @(negedge clk);
    flash = 2'b11; pll = 1'b1; wake = 1'b1; xfer_n = 1'b0; rtc_n = 1'b0;
    tick(5);
    flash = 2'b00; pll = 1'b0; wake = 1'b0; xfer_n = 1'b1; rtc_n = 1'b1;
    tick(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    for (int a = 0; a < 5; a++) rchk("R1", a[2:0], 8'h00);
    ichk("R1", 7'h00);

    // R2 register sweep
    for (int d = 0; d < 256; d++) begin
      wr(3'd0, d[7:0]); rchk("R2", 3'd0, d[7:0] & 8'h7F);
      wr(3'd2, d[7:0]); rchk("R2", 3'd2, d[7:0] & 8'h0F);
      wr(3'd4, d[7:0]); rchk("R2", 3'd4, d[7:0] & 8'h03);
    end
    wr(3'd1, 8'hFF); rchk("R2", 3'd1, 8'h00);
    wr(3'd2, 8'h00); wr(3'd4, 8'h00); wr(3'd0, 8'h7F);

    // R3 exact latency on line 0
    @(negedge clk); ext_pin[0] = 1'b1;
    @(negedge clk); @(negedge clk); chk("R3", irq, 7'h00);
    @(negedge clk); chk("R3", irq, 7'h01);
    do_ack(7'h01); ichk("R3", 7'h00);
    tick(4); ichk("R3", 7'h00);
    ext_pin[0] = 1'b0; tick(5); ichk("R3", 7'h00);
    // line 1 rising, line 5 falling on active-low pin
    ext_pin[1] = 1'b1; tick(5); ichk("R3", 7'h02);
    do_ack(7'h02); ext_pin[1] = 1'b0; tick(5); ichk("R3", 7'h00);
    ext_pin[3] = 1'b0; tick(5); ichk("R3", 7'h20); rchk("R3", 3'd1, 8'h20);
    do_ack(7'h20); ext_pin[3] = 1'b1; tick(5); ichk("R3", 7'h00);

    // R4 line 3 polarity
    ext_pin[2] = 1'b1; tick(5); ichk("R4", 7'h08);
    do_ack(7'h08); ext_pin[2] = 1'b0; tick(5); ichk("R4", 7'h00);
    wr(3'd4, 8'h02);
    ext_pin[2] = 1'b1; tick(5); ichk("R4", 7'h00);
    ext_pin[2] = 1'b0; tick(5); ichk("R4", 7'h08);
    do_ack(7'h08);
    // R4 line 2 falling: fires when merged flash signal drops
    wr(3'd4, 8'h01); wr(3'd2, 8'h04);
    ev(2); ichk("R4", 7'h00); rchk("R4", 3'd3, 8'h04);
    wr(3'd3, 8'hFB); tick(2); ichk("R4", 7'h04);
    do_ack(7'h04);
    wr(3'd4, 8'h00);
    ev(3); ichk("R9", 7'h04); rchk("R9", 3'd3, 8'h08);
    do_ack(7'h04); wr(3'd3, 8'h00); wr(3'd2, 8'h00); ichk("R9", 7'h00);

    // R5 gating and acknowledge
    wr(3'd0, 8'h00);
    ext_pin[0] = 1'b1; tick(5); ichk("R5", 7'h00); rchk("R5", 3'd1, 8'h01);
    wr(3'd0, 8'h01); ichk("R5", 7'h01);
    do_ack(7'h01); rchk("R5", 3'd1, 8'h00);
    ext_pin[0] = 1'b0; tick(5); wr(3'd0, 8'h7F);

    // R6 single sources
    for (int s = 0; s < 7; s++) begin
      wr(3'd3, 8'h00);
      ev(s);
      rchk("R6", 3'd3, 8'h01 << s);
    end
    wr(3'd3, 8'h00);
    // active-low release is no event
    xfer_n = 1'b0; tick(6); rchk("R6", 3'd3, 8'h01);
    wr(3'd3, 8'h00); xfer_n = 1'b1; tick(6); rchk("R6", 3'd3, 8'h00);

    // R7 clear mask sweep
    for (int p = 0; p < 128; p++) begin
      all_subs();
      rchk("R6", 3'd3, 8'h7F);
      wr(3'd3, {1'b0, p[6:0]});
      rchk("R7", 3'd3, {1'b0, p[6:0]});
      wr(3'd3, 8'h00);
    end
    wr(3'd3, 8'hFF); rchk("R7", 3'd3, 8'h00);
    all_subs();
    wr(3'd0, 8'h00); wr(3'd2, 8'h00); wr(3'd4, 8'h00); wr(3'd1, 8'h00);
    rchk("R7", 3'd3, 8'h7F);
    wr(3'd3, 8'h00); wr(3'd0, 8'h7F);

    // R8 set coincides with a clearing write
    @(negedge clk); wake = 1'b1;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 3'd3; wdata = 8'h00;
    @(negedge clk); we = 1'b0;
    rchk("R8", 3'd3, 8'h40);
    wake = 1'b0; tick(4); wr(3'd3, 8'h00);

    // R9 merging on line 6 and line 4
    wr(3'd2, 8'h0F);
    ev(0); ichk("R9", 7'h40);
    do_ack(7'h40); wr(3'd3, 8'h00);
    ev(4); ichk("R9", 7'h10); do_ack(7'h10); wr(3'd3, 8'h00);
    ev(5); ichk("R9", 7'h10); do_ack(7'h10); wr(3'd3, 8'h00);
    wr(3'd2, 8'h0E);
    ev(0); ichk("R9", 7'h00); rchk("R9", 3'd3, 8'h01);
    wr(3'd2, 8'h0F); tick(1); ichk("R9", 7'h40);
    do_ack(7'h40); wr(3'd3, 8'h00);

    // R10 lock-up: second sub-flag while first still set
    ev(0); ichk("R10", 7'h40);
    do_ack(7'h40); ichk("R10", 7'h00);
    ev(1); ichk("R10", 7'h00); rchk("R10", 3'd3, 8'h03);
    wr(3'd3, 8'hFE); tick(1); ichk("R10", 7'h00); rchk("R10", 3'd3, 8'h02);
    wr(3'd3, 8'hFD); tick(1); ichk("R10", 7'h00);
    ev(0); ichk("R10", 7'h40);
    do_ack(7'h40); wr(3'd3, 8'h00);

    // R11 wake raises nothing
    ev(6); ichk("R11", 7'h00); rchk("R11", 3'd3, 8'h40); rchk("R11", 3'd1, 8'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule